// File: doc/BRIEF.md
# Buck Converter Start-Up and Fault Sequencer

This block is the digital control state machine of a synchronous step-down converter controller. It watches a supply-good flag, a shutdown request and three comparator results: over-current, feedback under-voltage and feedback over-voltage. From these it decides when the converter may switch and what reference code the error path should use. It also decides when the low-side switch must be held on, and when the controller has given up after repeated over-current.

After supply-good rises and shutdown is released, the block runs a soft-start. A digital reference code rises from zero by one step every fixed number of clock ticks until it reaches the regulation code. The block then regulates. An over-current event restarts the soft-start and is counted. The event that reaches the count limit (four by default) latches the block off. An under-voltage during regulation stops switching for a fixed hiccup delay and then restarts, with no latching. Under-voltage is ignored while the ramp is running. Over-voltage during regulation raises a force-low-side request for as long as the comparator stays high. Shutdown or loss of supply-good stops everything, clears the event count and releases the latch.

Top module: `buck_seq_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, ref_code is 0 and reg_en, force_low and latched_off are all 0.
- R2: While supply_ok is 0 or shdn_req is 1, the block stays off: reg_en 0, ref_code 0, latched_off 0.
- R3: One clock edge after the start condition holds (supply_ok 1, shdn_req 0), reg_en is 1 and ref_code is 0. ref_code then rises by exactly 1 every STEP_TICKS edges. After k edges in soft-start it equals floor(k/STEP_TICKS).
- R4: Once ref_code equals REF_CODE, the next edge enters regulation. ref_code holds REF_CODE for as long as regulation lasts.
- R5: An over-current (oc_trip 1) during soft-start or regulation that does not reach the limit restarts soft-start at the next edge. ref_code returns to 0, reg_en stays 1, and the event is counted.
- R6: An under-voltage (uv_trip 1) during regulation turns switching off at the next edge (reg_en 0, ref_code 0). After exactly HICCUP_TICKS edges in the wait state, a new soft-start begins. This repeats any number of times without latching.
- R7: uv_trip has no effect during soft-start. The ramp continues as in R3.
- R8: force_low equals ov_trip in the same cycle while the block is regulating. It is 0 in every other state, including soft-start at the regulation code.
- R9: The OC_LIMIT-th counted over-current (4 by default) latches the block at the next edge: latched_off 1, reg_en 0, ref_code 0.
- R10: Once latched, the block ignores oc_trip, uv_trip and ov_trip (force_low 0) as long as supply_ok is 1 and shdn_req is 0.
- R11: shdn_req 1 turns the block off at the next edge from any state, clears the latch and the over-current count, and releasing it starts a fresh soft-start.
- R12: supply_ok 0 turns the block off at the next edge from any state, clearing the latch and the over-current count, exactly like R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above its power-on threshold |
| shdn_req | input | 1 | Shutdown pin held low |
| oc_trip | input | 1 | Over-current comparator result |
| uv_trip | input | 1 | Feedback below the under-voltage threshold |
| ov_trip | input | 1 | Feedback above the over-voltage threshold |
| ref_code | output | CODE_W | Reference code for the error path, the ramp during soft-start |
| reg_en | output | 1 | Switching allowed (soft-start or regulation) |
| force_low | output | 1 | Request to hold the low-side switch on |
| latched_off | output | 1 | Latched off after repeated over-current |

## Verification
Every state change happens at the clock edge after the input that causes it, so ref_code, reg_en and latched_off are due one edge after a stimulus. ref_code then moves one step every STEP_TICKS edges. The hiccup restart is due HICCUP_TICKS edges after entering the wait. force_low is combinational from ov_trip and is due in the same cycle. The bench drives inputs on the falling edge and samples either a falling edge later or one time unit after driving force_low. It counts edges from each entry and compares against floor(k/STEP_TICKS) for every ramp cycle, and against the exact hiccup length.

// File: rtl/buck_seq_pkg.sv
// Shared types for the buck start-up and fault sequencer.
// Assumes: nothing beyond a 1800-2017 compiler.
package buck_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_SS    = 3'd1,
        ST_RUN   = 3'd2,
        ST_HIC   = 3'd3,
        ST_LATCH = 3'd4
    } seq_state_t;
endpackage

// File: rtl/buck_ss_ramp.sv
// Soft-start ramp: a code that climbs by one every STEP_TICKS cycles
// while active, and stops at REF_CODE.
// Assumes: restart has priority and zeroes code and tick counter.
module buck_ss_ramp #(
    parameter int CODE_W     = 8,
    parameter int REF_CODE   = 200,
    parameter int STEP_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              active,
    output logic [CODE_W-1:0] code_q,
    output logic              at_ref
);
    localparam int TICK_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;

    logic [TICK_W-1:0] tick_q;

    assign at_ref = (code_q == CODE_W'(REF_CODE));

    // Advance the tick divider and the ramp code.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            code_q <= '0;
            tick_q <= '0;
        end else if (active && !at_ref) begin
            if (tick_q == TICK_W'(STEP_TICKS - 1)) begin
                tick_q <= '0;
                code_q <= code_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    // R3
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !restart) |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1));
    // R3
    ramp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (code_q == '0));
endmodule

// File: rtl/buck_oc_tally.sv
// Over-current event counter. Flags when the next event reaches the limit.
// Assumes: clr has priority over evt; the count saturates at OC_LIMIT.
module buck_oc_tally #(
    parameter int OC_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic evt,
    output logic last
);
    localparam int CNT_W = $clog2(OC_LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == CNT_W'(OC_LIMIT - 1));

    // Count events, clearing on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (evt && cnt_q < CNT_W'(OC_LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R11
    tally_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
    // R5
    tally_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr && cnt_q < CNT_W'(OC_LIMIT)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/buck_hiccup_timer.sv
// Hiccup delay: counts cycles while run is high and flags the last one.
// Assumes: run falls the cycle after done, which restarts the count.
module buck_hiccup_timer #(
    parameter int HICCUP_TICKS = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = (HICCUP_TICKS > 1) ? $clog2(HICCUP_TICKS) : 1;

    logic [W-1:0] cnt_q;

    assign done = run && (cnt_q == W'(HICCUP_TICKS - 1));

    // Count the cycles spent waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    hic_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (!run || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/buck_seq_ctrl.sv
// Start-up and fault sequencer for a synchronous buck controller.
// States: off, soft-start, regulation, hiccup wait, latched.
// Assumes: all inputs are already synchronous to clk and filtered.
module buck_seq_ctrl #(
    parameter int CODE_W       = 8,
    parameter int REF_CODE     = 200,
    parameter int STEP_TICKS   = 16,
    parameter int HICCUP_TICKS = 20000,
    parameter int OC_LIMIT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              shdn_req,
    input  logic              oc_trip,
    input  logic              uv_trip,
    input  logic              ov_trip,
    output logic [CODE_W-1:0] ref_code,
    output logic              reg_en,
    output logic              force_low,
    output logic              latched_off
);
    import buck_seq_pkg::*;

    seq_state_t        st_q, st_d;
    logic              live, ss_start, oc_evt;
    logic              at_ref, oc_last, hic_done;
    logic [CODE_W-1:0] ramp_code;

    assign live = supply_ok && !shdn_req;

    buck_ss_ramp #(
        .CODE_W(CODE_W), .REF_CODE(REF_CODE), .STEP_TICKS(STEP_TICKS)
    ) u_ramp (
        .clk(clk), .rst_n(rst_n), .restart(ss_start),
        .active(st_q == ST_SS), .code_q(ramp_code), .at_ref(at_ref)
    );

    buck_oc_tally #(.OC_LIMIT(OC_LIMIT)) u_tally (
        .clk(clk), .rst_n(rst_n), .clr(!live), .evt(oc_evt), .last(oc_last)
    );

    buck_hiccup_timer #(.HICCUP_TICKS(HICCUP_TICKS)) u_hic (
        .clk(clk), .rst_n(rst_n), .run(st_q == ST_HIC), .done(hic_done)
    );

    // Next-state decision with shutdown and supply loss on top.
    always_comb begin
        st_d     = st_q;
        ss_start = 1'b0;
        oc_evt   = 1'b0;
        if (!live) begin
            st_d = ST_OFF;
        end else begin
            case (st_q)
                ST_OFF: begin
                    st_d     = ST_SS;
                    ss_start = 1'b1;
                end
                ST_SS, ST_RUN: begin
                    if (oc_trip) begin
                        oc_evt = 1'b1;
                        if (oc_last) begin
                            st_d = ST_LATCH;
                        end else begin
                            st_d     = ST_SS;
                            ss_start = 1'b1;
                        end
                    end else if (st_q == ST_SS) begin
                        if (at_ref) st_d = ST_RUN;
                    end else if (uv_trip) begin
                        st_d = ST_HIC;
                    end
                end
                ST_HIC: begin
                    if (hic_done) begin
                        st_d     = ST_SS;
                        ss_start = 1'b1;
                    end
                end
                ST_LATCH: st_d = ST_LATCH;
                default:  st_d = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    assign reg_en      = (st_q == ST_SS) || (st_q == ST_RUN);
    assign ref_code    = reg_en ? ramp_code : '0;
    assign force_low   = (st_q == ST_RUN) && ov_trip;
    assign latched_off = (st_q == ST_LATCH);

    // R12
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!reg_en && !latched_off && ref_code == '0));
    // R11
    shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req |=> (!reg_en && !latched_off && ref_code == '0));
    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && live) |=> latched_off);
    // R7
    uv_ignored_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SS && uv_trip && !oc_trip && live) |=> reg_en);
    // R4
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (ref_code == CODE_W'(REF_CODE)));
endmodule

// File: tb/buck_seq_ctrl_tb.sv
module buck_seq_ctrl_tb;
    localparam int CLK_P  = 10;
    localparam int CW     = 4;
    localparam int REF    = 6;
    localparam int STEP   = 2;
    localparam int HIC    = 5;
    localparam int LIMIT  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, shdn_req = 1'b0;
    logic oc_trip = 1'b0, uv_trip = 1'b0, ov_trip = 1'b0;
    logic [CW-1:0] ref_code;
    logic reg_en, force_low, latched_off;
    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_P / 2) clk = ~clk;

    buck_seq_ctrl #(
        .CODE_W(CW), .REF_CODE(REF), .STEP_TICKS(STEP),
        .HICCUP_TICKS(HIC), .OC_LIMIT(LIMIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shdn_req(shdn_req),
        .oc_trip(oc_trip), .uv_trip(uv_trip), .ov_trip(ov_trip),
        .ref_code(ref_code), .reg_en(reg_en), .force_low(force_low),
        .latched_off(latched_off)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_off(input string req);
        chk(req, int'(reg_en), 0);
        chk(req, int'(ref_code), 0);
        chk(req, int'(latched_off), 0);
    endtask

    // Called at a falling edge once the start condition holds; checks the full ramp.
    task automatic ramp_up(input bit with_uv);
        uv_trip = with_uv;
        @(negedge clk);
        oc_trip = 1'b0;
        for (int k = 0; k <= REF * STEP; k++) begin
            chk(with_uv ? "R7 ramp under uv" : "R3 ramp code", int'(ref_code), k / STEP);
            chk("R3 reg_en in soft-start", int'(reg_en), 1);
            chk("R3 not latched", int'(latched_off), 0);
            if (k < REF * STEP) @(negedge clk);
        end
        ov_trip = 1'b1;
        uv_trip = 1'b0;
        #1;
        chk("R8 no clamp in soft-start", int'(force_low), 0);
        @(negedge clk);
        chk("R4 regulation code", int'(ref_code), REF);
        chk("R8 clamp in regulation", int'(force_low), 1);
        ov_trip = 1'b0;
        #1;
        chk("R8 clamp released", int'(force_low), 0);
    endtask

    task automatic oc_restarts(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            oc_trip = 1'b1;
            ramp_up(1'b0);
            chk(req, int'(latched_off), 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 reset
        repeat (3) @(negedge clk);
        chk_off("R1 reset");
        chk("R1 force_low", int'(force_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_off("R1 after reset");

        // R2 held off
        supply_ok = 1'b1; shdn_req = 1'b1; uv_trip = 1'b1; oc_trip = 1'b1;
        for (int i = 0; i < 4; i++) begin @(negedge clk); chk_off("R2 shutdown held"); end
        supply_ok = 1'b0; shdn_req = 1'b0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); chk_off("R2 supply low"); end
        oc_trip = 1'b0; uv_trip = 1'b0;

        // R3/R4/R8 first start, R7 ramp with uv held
        supply_ok = 1'b1;
        ramp_up(1'b1);

        // R6 hiccup twice
        for (int rep = 0; rep < 2; rep++) begin
            uv_trip = 1'b1;
            @(negedge clk);
            uv_trip = 1'b0;
            chk_off("R6 hiccup off");
            for (int k = 2; k <= HIC; k++) begin
                @(negedge clk);
                chk_off("R6 hiccup wait");
            end
            ramp_up(1'b0);
        end

        // R5 restarts, R9 latch on the 4th
        oc_restarts("R5 restart not latched", LIMIT - 1);
        oc_trip = 1'b1;
        @(negedge clk);
        oc_trip = 1'b0;
        chk("R9 latched", int'(latched_off), 1);
        chk("R9 reg_en", int'(reg_en), 0);
        chk("R9 ref_code", int'(ref_code), 0);

        // R10 latch holds
        for (int i = 0; i < 12; i++) begin
            oc_trip = i[0]; uv_trip = i[1]; ov_trip = 1'b1;
            @(negedge clk);
            chk("R10 latch holds", int'(latched_off), 1);
            chk("R10 no switching", int'(reg_en), 0);
            chk("R10 no clamp", int'(force_low), 0);
        end
        oc_trip = 1'b0; uv_trip = 1'b0; ov_trip = 1'b0;

        // R11 shutdown clears latch and count
        shdn_req = 1'b1;
        for (int i = 0; i < 3; i++) begin @(negedge clk); chk_off("R11 shutdown"); end
        shdn_req = 1'b0;
        ramp_up(1'b0);
        oc_restarts("R11 count cleared", LIMIT - 1);
        oc_trip = 1'b1;
        @(negedge clk);
        oc_trip = 1'b0;
        chk("R11 latch after fresh count", int'(latched_off), 1);

        // R12 supply loss clears latch and count
        supply_ok = 1'b0;
        @(negedge clk);
        chk_off("R12 supply loss");
        supply_ok = 1'b1;
        ramp_up(1'b0);
        oc_restarts("R12 count cleared", LIMIT - 1);
        supply_ok = 1'b0;
        @(negedge clk);
        chk_off("R12 supply loss in regulation");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule